// File: doc/BRIEF.md
# Peripheral-to-Channel Map Builder

This block builds, in hardware, the table that translates a 12-bit peripheral identifier into the arbiter channel that serves it, and records for every channel which execution environment may write through it and which one receives its interrupts. A one-cycle start pulse empties the table. The block then fetches a version word, which sets how many channels exist. For each channel in turn it fetches a channel map word and, when that word is non-zero, an ownership word. All fetches use one request/acknowledge read port.

When two channels name the same peripheral, a priority rule settles which one keeps the table slot. A channel written by the local environment always takes the slot. A later foreign channel that owns interrupts instead passes its interrupt owner onto the local channel that already holds the slot. Once the scan completes, a registered lookup port answers queries by peripheral identifier. It returns the channel, its write owner and its interrupt owner. While a scan runs it answers with a busy indication instead.

Top module: `chanmap_builder`

## Requirements
- R1: A start pulse seen while idle clears every table valid flag, raises busy and makes the first read request a version fetch (select code 0); busy stays high through the done cycle.
- R2: A version word below VER_MIN (0x5000_0000) ends the scan with done and the unsupported flag high in the same cycle, with no map or ownership fetch; afterwards every lookup misses.
- R3: A version word at or above VER_MIN and below VER_SPLIT (0x7000_0000) scans channels 0 to NCH_LO-1; at or above VER_SPLIT it scans 0 to NCH_HI-1; map fetches go in ascending channel order, one per channel.
- R4: A read request holds its select (0 version, 1 channel map, 2 ownership) and channel index unchanged until the cycle in which rd_ack is high; rd_data is taken in that cycle.
- R5: In a map word, bits 19:8 give the peripheral identifier and bit 14 (which is also identifier bit 6) marks interrupt ownership; an all-zero map word is skipped with no ownership fetch, and bits 31:20 are ignored.
- R6: A channel's write owner is bits 2:0 of its ownership word; its interrupt owner is that write owner when the interrupt flag is set, otherwise 0xFF.
- R7: A scanned channel takes its identifier's slot when the slot is not yet valid, or when its write owner equals LOCAL_EE.
- R8: A channel that does not take a valid slot, but owns interrupts while the slot's current channel has write owner LOCAL_EE, copies its interrupt owner onto that current channel.
- R9: A lookup request gets a response one cycle later; on a hit it gives the channel index, the write owner and the interrupt owner of the mapped channel, and on a miss hit is low with all data fields zero.
- R10: A lookup requested while busy returns busy indication high and hit low.
- R11: A start pulse while busy is ignored: the running scan neither restarts nor repeats its version fetch.
- R12: Done is a single-cycle pulse following the last channel's processing, after which busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scan_start | input | 1 | Start pulse for a new scan |
| scan_busy | output | 1 | Scan in progress |
| scan_done | output | 1 | One-cycle end-of-scan pulse |
| scan_unsup | output | 1 | High with scan_done when the version is unsupported |
| rd_req | output | 1 | Read request |
| rd_sel | output | 2 | Read target: 0 version, 1 channel map, 2 ownership |
| rd_idx | output | clog2(NCH_HI) | Channel index of the read |
| rd_ack | input | 1 | Read acknowledge, data valid this cycle |
| rd_data | input | 32 | Read data |
| lk_req | input | 1 | Lookup request |
| lk_ppid | input | 12 | Peripheral identifier to look up |
| lk_rsp | output | 1 | Lookup response valid |
| lk_busy | output | 1 | Lookup refused because a scan was running |
| lk_hit | output | 1 | Identifier is mapped |
| lk_chan | output | 15 | Channel index of the mapping |
| lk_wown | output | 3 | Write owner of the mapped channel |
| lk_iown | output | 8 | Interrupt owner of the mapped channel |

## Verification
The bench builds the block with NCH_LO = 8, NCH_HI = 16 and LOCAL_EE = 1. Short scans let many complete runs fit: both scan lengths, the unsupported version, restarts over stale content, and starts issued mid-scan. Map words draw identifiers from a pool of eight, so duplicate identifiers with mixed local and foreign owners come up in almost every run. This exercises the slot-claim priority and the interrupt hand-over repeatedly. The full 4096-slot table is kept, so identifiers at both ends of the range stay reachable.

// File: rtl/chanmap_pkg.sv
package chanmap_pkg;
  localparam int PPID_W       = 12;
  localparam int SLOTS        = 1 << PPID_W;
  localparam int WORD_W       = 32;
  localparam int EE_W         = 3;
  localparam int IRQ_W        = 8;
  localparam int CHAN_OUT_W   = 15;
  localparam int PPID_LSB     = 8;
  localparam int IRQ_FLAG_BIT = 14;
  localparam logic [IRQ_W-1:0] IRQ_NONE = 8'hFF;

  localparam logic [1:0] SEL_VER = 2'd0;
  localparam logic [1:0] SEL_MAP = 2'd1;
  localparam logic [1:0] SEL_OWN = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_VER  = 3'd1,
    ST_MAP  = 3'd2,
    ST_OWN  = 3'd3,
    ST_UPD  = 3'd4,
    ST_DONE = 3'd5
  } scan_st_e;
endpackage

// File: rtl/chanmap_slot_table.sv
module chanmap_slot_table
  import chanmap_pkg::*;
#(
  parameter int CH_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              we,
  input  logic [PPID_W-1:0] waddr,
  input  logic [CH_W-1:0]   wchan,
  input  logic [PPID_W-1:0] scan_addr,
  output logic              scan_valid,
  output logic [CH_W-1:0]   scan_chan,
  input  logic [PPID_W-1:0] lk_addr,
  output logic              lk_valid,
  output logic [CH_W-1:0]   lk_chan
);
  logic [SLOTS-1:0] valid_q, valid_d;
  logic [CH_W-1:0]  chan_mem [SLOTS];

  always_comb begin
    valid_d = valid_q;
    if (clr_all) begin
      valid_d = '0;
    end else if (we) begin
      valid_d[waddr] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (clr_all || we) begin
      valid_q <= valid_d;
    end
  end

  // Channel field carries no reset: it is only read behind a valid flag.
  always_ff @(posedge clk) begin
    if (we) begin
      chan_mem[waddr] <= wchan;
    end
  end

  assign scan_valid = valid_q[scan_addr];
  assign scan_chan  = chan_mem[scan_addr];
  assign lk_valid   = valid_q[lk_addr];
  assign lk_chan    = chan_mem[lk_addr];
endmodule

// File: rtl/chanmap_owner_store.sv
module chanmap_owner_store
  import chanmap_pkg::*;
#(
  parameter int NCH  = 1024,
  parameter int CH_W = 10
) (
  input  logic             clk,
  input  logic             set_we,
  input  logic [CH_W-1:0]  set_idx,
  input  logic [EE_W-1:0]  set_wown,
  input  logic [IRQ_W-1:0] set_iown,
  input  logic             mv_we,
  input  logic [CH_W-1:0]  mv_idx,
  input  logic [IRQ_W-1:0] mv_iown,
  input  logic [CH_W-1:0]  scan_idx,
  output logic [EE_W-1:0]  scan_wown,
  input  logic [CH_W-1:0]  lk_idx,
  output logic [EE_W-1:0]  lk_wown,
  output logic [IRQ_W-1:0] lk_iown
);
  logic [EE_W-1:0]  wown_mem [NCH];
  logic [IRQ_W-1:0] iown_mem [NCH];

  always_ff @(posedge clk) begin
    if (set_we) begin
      wown_mem[set_idx] <= set_wown;
    end
  end

  // Two write ports onto the interrupt owner: the channel being recorded
  // and the earlier local channel receiving a hand-over.
  always_ff @(posedge clk) begin
    if (set_we) begin
      iown_mem[set_idx] <= set_iown;
    end
    if (mv_we) begin
      iown_mem[mv_idx] <= mv_iown;
    end
  end

  assign scan_wown = wown_mem[scan_idx];
  assign lk_wown   = wown_mem[lk_idx];
  assign lk_iown   = iown_mem[lk_idx];
endmodule

// File: rtl/chanmap_scan_fsm.sv
module chanmap_scan_fsm
  import chanmap_pkg::*;
#(
  parameter int                NCH_LO    = 512,
  parameter int                NCH_HI    = 1024,
  parameter int                CH_W      = 10,
  parameter logic [WORD_W-1:0] VER_MIN   = 32'h5000_0000,
  parameter logic [WORD_W-1:0] VER_SPLIT = 32'h7000_0000,
  parameter logic [EE_W-1:0]   LOCAL_EE  = 3'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              unsup,
  output logic              rd_req,
  output logic [1:0]        rd_sel,
  output logic [CH_W-1:0]   rd_idx,
  input  logic              rd_ack,
  input  logic [WORD_W-1:0] rd_data,
  output logic              clr_all,
  output logic [PPID_W-1:0] cur_ppid,
  input  logic              slot_valid,
  input  logic [CH_W-1:0]   slot_chan,
  input  logic [EE_W-1:0]   last_wown,
  output logic              tbl_we,
  output logic              own_we,
  output logic [EE_W-1:0]   own_wown,
  output logic [IRQ_W-1:0]  own_iown,
  output logic              mv_we
);
  localparam logic [CH_W-1:0] LO_END = CH_W'(NCH_LO - 1);
  localparam logic [CH_W-1:0] HI_END = CH_W'(NCH_HI - 1);

  scan_st_e          st_q, st_d;
  logic [CH_W-1:0]   chan_q, chan_d;
  logic [CH_W-1:0]   end_q, end_d;
  logic [PPID_W-1:0] ppid_q, ppid_d;
  logic              irq_q, irq_d;
  logic [EE_W-1:0]   wown_q, wown_d;
  logic              unsup_q, unsup_d;
  logic              at_end;
  logic              claim;
  logic              step;

  assign at_end   = (chan_q == end_q);
  assign claim    = !slot_valid || (wown_q == LOCAL_EE);
  assign own_wown = wown_q;
  assign own_iown = irq_q ? IRQ_W'(wown_q) : IRQ_NONE;
  assign cur_ppid = ppid_q;

  always_comb begin
    st_d    = st_q;
    chan_d  = chan_q;
    end_d   = end_q;
    ppid_d  = ppid_q;
    irq_d   = irq_q;
    wown_d  = wown_q;
    unsup_d = unsup_q;
    clr_all = 1'b0;
    tbl_we  = 1'b0;
    own_we  = 1'b0;
    mv_we   = 1'b0;
    step    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          clr_all = 1'b1;
          unsup_d = 1'b0;
          chan_d  = '0;
          st_d    = ST_VER;
        end
      end
      ST_VER: begin
        if (rd_ack) begin
          if (rd_data < VER_MIN) begin
            unsup_d = 1'b1;
            st_d    = ST_DONE;
          end else begin
            end_d = (rd_data < VER_SPLIT) ? LO_END : HI_END;
            st_d  = ST_MAP;
          end
        end
      end
      ST_MAP: begin
        if (rd_ack) begin
          if (rd_data == '0) begin
            step = 1'b1;
          end else begin
            ppid_d = rd_data[PPID_LSB +: PPID_W];
            irq_d  = rd_data[IRQ_FLAG_BIT];
            st_d   = ST_OWN;
          end
        end
      end
      ST_OWN: begin
        if (rd_ack) begin
          wown_d = rd_data[EE_W-1:0];
          st_d   = ST_UPD;
        end
      end
      ST_UPD: begin
        own_we = 1'b1;
        if (claim) begin
          tbl_we = 1'b1;
        end else if (irq_q && (last_wown == LOCAL_EE)) begin
          mv_we = 1'b1;
        end
        step = 1'b1;
      end
      ST_DONE: begin
        st_d = ST_IDLE;
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
    if (step) begin
      if (at_end) begin
        st_d = ST_DONE;
      end else begin
        chan_d = chan_q + 1'b1;
        st_d   = ST_MAP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      chan_q  <= '0;
      end_q   <= '0;
      ppid_q  <= '0;
      irq_q   <= 1'b0;
      wown_q  <= '0;
      unsup_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      chan_q  <= chan_d;
      end_q   <= end_d;
      ppid_q  <= ppid_d;
      irq_q   <= irq_d;
      wown_q  <= wown_d;
      unsup_q <= unsup_d;
    end
  end

  assign busy   = (st_q != ST_IDLE);
  assign done   = (st_q == ST_DONE);
  assign unsup  = done && unsup_q;
  assign rd_req = (st_q == ST_VER) || (st_q == ST_MAP) || (st_q == ST_OWN);
  assign rd_idx = chan_q;

  always_comb begin
    case (st_q)
      ST_MAP:  rd_sel = SEL_MAP;
      ST_OWN:  rd_sel = SEL_OWN;
      default: rd_sel = SEL_VER;
    endcase
  end
endmodule

// File: rtl/chanmap_builder.sv
module chanmap_builder
  import chanmap_pkg::*;
#(
  parameter int          NCH_LO    = 512,
  parameter int          NCH_HI    = 1024,
  parameter logic [31:0] VER_MIN   = 32'h5000_0000,
  parameter logic [31:0] VER_SPLIT = 32'h7000_0000,
  parameter logic [2:0]  LOCAL_EE  = 3'd0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scan_start,
  output logic                      scan_busy,
  output logic                      scan_done,
  output logic                      scan_unsup,
  output logic                      rd_req,
  output logic [1:0]                rd_sel,
  output logic [$clog2(NCH_HI)-1:0] rd_idx,
  input  logic                      rd_ack,
  input  logic [31:0]               rd_data,
  input  logic                      lk_req,
  input  logic [11:0]               lk_ppid,
  output logic                      lk_rsp,
  output logic                      lk_busy,
  output logic                      lk_hit,
  output logic [14:0]               lk_chan,
  output logic [2:0]                lk_wown,
  output logic [7:0]                lk_iown
);
  localparam int CH_W = $clog2(NCH_HI);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic              clr_all, tbl_we, own_we, mv_we;
  logic [PPID_W-1:0] cur_ppid;
  logic              slot_valid;
  logic [CH_W-1:0]   slot_chan;
  logic [EE_W-1:0]   last_wown;
  logic [EE_W-1:0]   own_wown;
  logic [IRQ_W-1:0]  own_iown;
  logic              tab_lk_valid;
  logic [CH_W-1:0]   tab_lk_chan;
  logic [EE_W-1:0]   st_lk_wown;
  logic [IRQ_W-1:0]  st_lk_iown;

  chanmap_scan_fsm #(
    .NCH_LO   (NCH_LO),
    .NCH_HI   (NCH_HI),
    .CH_W     (CH_W),
    .VER_MIN  (VER_MIN),
    .VER_SPLIT(VER_SPLIT),
    .LOCAL_EE (LOCAL_EE)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (scan_start),
    .busy      (scan_busy),
    .done      (scan_done),
    .unsup     (scan_unsup),
    .rd_req    (rd_req),
    .rd_sel    (rd_sel),
    .rd_idx    (rd_idx),
    .rd_ack    (rd_ack),
    .rd_data   (rd_data),
    .clr_all   (clr_all),
    .cur_ppid  (cur_ppid),
    .slot_valid(slot_valid),
    .slot_chan (slot_chan),
    .last_wown (last_wown),
    .tbl_we    (tbl_we),
    .own_we    (own_we),
    .own_wown  (own_wown),
    .own_iown  (own_iown),
    .mv_we     (mv_we)
  );

  chanmap_slot_table #(
    .CH_W(CH_W)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr_all   (clr_all),
    .we        (tbl_we),
    .waddr     (cur_ppid),
    .wchan     (rd_idx),
    .scan_addr (cur_ppid),
    .scan_valid(slot_valid),
    .scan_chan (slot_chan),
    .lk_addr   (lk_ppid),
    .lk_valid  (tab_lk_valid),
    .lk_chan   (tab_lk_chan)
  );

  chanmap_owner_store #(
    .NCH (NCH_HI),
    .CH_W(CH_W)
  ) u_owners (
    .clk      (clk),
    .set_we   (own_we),
    .set_idx  (rd_idx),
    .set_wown (own_wown),
    .set_iown (own_iown),
    .mv_we    (mv_we),
    .mv_idx   (slot_chan),
    .mv_iown  (own_iown),
    .scan_idx (slot_chan),
    .scan_wown(last_wown),
    .lk_idx   (tab_lk_chan),
    .lk_wown  (st_lk_wown),
    .lk_iown  (st_lk_iown)
  );

  // Lookup response stage
  logic                  rsp_d, lbusy_d, hit_d;
  logic [CHAN_OUT_W-1:0] chan_d;
  logic [EE_W-1:0]       wown_d;
  logic [IRQ_W-1:0]      iown_d;

  always_comb begin
    rsp_d   = lk_req;
    lbusy_d = lk_req && scan_busy;
    hit_d   = lk_req && !scan_busy && tab_lk_valid;
    chan_d  = hit_d ? CHAN_OUT_W'(tab_lk_chan) : '0;
    wown_d  = hit_d ? st_lk_wown : '0;
    iown_d  = hit_d ? st_lk_iown : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      lk_rsp  <= 1'b0;
      lk_busy <= 1'b0;
      lk_hit  <= 1'b0;
      lk_chan <= '0;
      lk_wown <= '0;
      lk_iown <= '0;
    end else begin
      lk_rsp  <= rsp_d;
      lk_busy <= lbusy_d;
      lk_hit  <= hit_d;
      lk_chan <= chan_d;
      lk_wown <= wown_d;
      lk_iown <= iown_d;
    end
  end
endmodule

// File: rtl/chanmap_builder_chk.sv
module chanmap_builder_chk #(
  parameter int CH_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            unsup,
  input logic            rd_req,
  input logic [1:0]      rd_sel,
  input logic [CH_W-1:0] rd_idx,
  input logic            rd_ack,
  input logic            lk_req,
  input logic            lk_rsp,
  input logic            lk_busy,
  input logic            lk_hit
);
  p_start_first_ver_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && rd_req && (rd_sel == 2'd0));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req && !done);

  p_unsup_with_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    unsup |-> done);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_sel) && $stable(rd_idx));

  p_lk_rsp_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> lk_rsp);

  p_lk_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req && busy |=> lk_busy && !lk_hit);

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
endmodule

bind chanmap_builder chanmap_builder_chk #(.CH_W(CH_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_int_n),
  .start  (scan_start),
  .busy   (scan_busy),
  .done   (scan_done),
  .unsup  (scan_unsup),
  .rd_req (rd_req),
  .rd_sel (rd_sel),
  .rd_idx (rd_idx),
  .rd_ack (rd_ack),
  .lk_req (lk_req),
  .lk_rsp (lk_rsp),
  .lk_busy(lk_busy),
  .lk_hit (lk_hit)
);

// File: tb/chanmap_builder_tb.sv
module chanmap_builder_tb;
  localparam int          CLK_PERIOD = 10;
  localparam int          NCH_LO     = 8;
  localparam int          NCH_HI     = 16;
  localparam int          CH_W       = $clog2(NCH_HI);
  localparam logic [2:0]  LOCAL_EE   = 3'd1;
  localparam logic [31:0] V_MIN      = 32'h5000_0000;
  localparam logic [31:0] V_SPLIT    = 32'h7000_0000;
  localparam int          WD_CYCLES  = 150000;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            scan_start;
  logic            scan_busy, scan_done, scan_unsup;
  logic            rd_req;
  logic [1:0]      rd_sel;
  logic [CH_W-1:0] rd_idx;
  logic            rd_ack;
  logic [31:0]     rd_data;
  logic            lk_req;
  logic [11:0]     lk_ppid;
  logic            lk_rsp, lk_busy, lk_hit;
  logic [14:0]     lk_chan;
  logic [2:0]      lk_wown;
  logic [7:0]      lk_iown;

  always #(CLK_PERIOD/2) clk = ~clk;

  chanmap_builder #(
    .NCH_LO(NCH_LO), .NCH_HI(NCH_HI), .VER_MIN(V_MIN), .VER_SPLIT(V_SPLIT),
    .LOCAL_EE(LOCAL_EE)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .scan_busy(scan_busy),
    .scan_done(scan_done), .scan_unsup(scan_unsup), .rd_req(rd_req),
    .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_ack(rd_ack), .rd_data(rd_data),
    .lk_req(lk_req), .lk_ppid(lk_ppid), .lk_rsp(lk_rsp), .lk_busy(lk_busy),
    .lk_hit(lk_hit), .lk_chan(lk_chan), .lk_wown(lk_wown), .lk_iown(lk_iown)
  );

  int checks = 0;
  int errors = 0;

  // Memory seen through the read port
  logic [31:0] cur_ver;
  logic [31:0] map_mem [NCH_HI];
  logic [31:0] own_mem [NCH_HI];

  // Expected results
  bit          exp_valid [4096];
  int          exp_ch    [4096];
  logic [2:0]  exp_w     [NCH_HI];
  logic [7:0]  exp_i     [NCH_HI];
  int          exp_len, exp_own;
  bit          exp_unsup;

  // Responder bookkeeping
  int ver_reads, map_reads, own_reads, next_map;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  function automatic void model();
    logic [11:0] p;
    logic        f;
    logic [2:0]  wo;
    for (int s = 0; s < 4096; s++) exp_valid[s] = 1'b0;
    exp_own   = 0;
    exp_unsup = (cur_ver < V_MIN);
    exp_len   = exp_unsup ? 0 : ((cur_ver < V_SPLIT) ? NCH_LO : NCH_HI);
    for (int c = 0; c < exp_len; c++) begin
      if (map_mem[c] != 32'h0) begin
        exp_own++;
        p  = map_mem[c][19:8];
        f  = map_mem[c][14];
        wo = own_mem[c][2:0];
        exp_w[c] = wo;
        exp_i[c] = f ? {5'b0, wo} : 8'hFF;
        if (!exp_valid[p] || wo == LOCAL_EE) begin
          exp_valid[p] = 1'b1;
          exp_ch[p]    = c;
        end else if (f && exp_w[exp_ch[p]] == LOCAL_EE) begin
          exp_i[exp_ch[p]] = exp_i[c];
        end
      end
    end
  endfunction

  // Read port responder: random 0..2 wait cycles, holds and order checked
  initial begin
    bit          pending = 1'b0;
    int          wait_left = 0;
    logic [1:0]  h_sel = 2'd0;
    logic [CH_W-1:0] h_idx = '0;
    rd_ack  = 1'b0;
    rd_data = 32'h0;
    forever begin
      @(negedge clk);
      rd_ack = 1'b0;
      if (rd_req) begin
        if (!pending) begin
          pending   = 1'b1;
          wait_left = $urandom % 3;
          h_sel     = rd_sel;
          h_idx     = rd_idx;
        end else if (rd_sel != h_sel || rd_idx != h_idx) begin
          chk(1'b0, "R4 request changed before ack", {rd_sel, rd_idx}, {h_sel, h_idx});
        end
        if (wait_left == 0) begin
          rd_ack  = 1'b1;
          pending = 1'b0;
          case (rd_sel)
            2'd0: begin rd_data = cur_ver; ver_reads++; end
            2'd1: begin
              rd_data = map_mem[rd_idx];
              if (int'(rd_idx) != next_map)
                chk(1'b0, "R3 map fetch order", rd_idx, next_map);
              next_map++;
              map_reads++;
            end
            default: begin rd_data = own_mem[rd_idx]; own_reads++; end
          endcase
        end else begin
          wait_left--;
        end
      end else begin
        pending = 1'b0;
      end
    end
  end

  task automatic lookup(input logic [11:0] p, input string tag);
    @(negedge clk);
    lk_req  = 1'b1;
    lk_ppid = p;
    @(negedge clk);
    lk_req = 1'b0;
    chk(lk_rsp == 1'b1, "R9 response one cycle after request", lk_rsp, 1);
    chk(lk_busy == 1'b0, "R10 no busy when idle", lk_busy, 0);
    chk(lk_hit == exp_valid[p], {tag, " hit"}, lk_hit, exp_valid[p]);
    if (exp_valid[p]) begin
      chk(lk_chan == 15'(exp_ch[p]), {tag, " R7 chan"}, lk_chan, exp_ch[p]);
      chk(lk_wown == exp_w[exp_ch[p]], {tag, " R6 write owner"}, lk_wown, exp_w[exp_ch[p]]);
      chk(lk_iown == exp_i[exp_ch[p]], {tag, " R8 irq owner"}, lk_iown, exp_i[exp_ch[p]]);
    end else begin
      chk(lk_chan == 0 && lk_wown == 0 && lk_iown == 0, {tag, " R9 miss fields zero"},
          {lk_chan, lk_wown, lk_iown}, 0);
    end
  endtask

  task automatic run_scan(input logic [31:0] ver, input bit busy_probe, input bit restart);
    cur_ver   = ver;
    ver_reads = 0; map_reads = 0; own_reads = 0; next_map = 0;
    model();
    @(negedge clk);
    scan_start = 1'b1;
    @(negedge clk);
    scan_start = 1'b0;
    chk(scan_busy == 1'b1, "R1 busy after start", scan_busy, 1);
    if (busy_probe && !scan_done) begin
      lk_req  = 1'b1;
      lk_ppid = 12'h0C5;
      @(negedge clk);
      lk_req = 1'b0;
      chk(lk_busy == 1'b1 && lk_hit == 1'b0, "R10 lookup during scan",
          {lk_busy, lk_hit}, 2'b10);
    end
    if (restart && !scan_done) begin
      scan_start = 1'b1;
      @(negedge clk);
      scan_start = 1'b0;
    end
    while (!scan_done) @(negedge clk);
    chk(scan_unsup == exp_unsup, "R2 unsupported flag at done", scan_unsup, exp_unsup);
    chk(ver_reads == 1, "R1/R11 single version fetch", ver_reads, 1);
    chk(map_reads == exp_len, "R3 map fetch count", map_reads, exp_len);
    chk(own_reads == exp_own, "R5 ownership fetch count", own_reads, exp_own);
    @(negedge clk);
    chk(scan_done == 1'b0 && scan_busy == 1'b0, "R12 done single pulse then idle",
        {scan_done, scan_busy}, 0);
  endtask

  task automatic check_list();
    lookup(12'h0C5, "A");
    lookup(12'h2D3, "B");
    lookup(12'h123, "C");
    lookup(12'h00A, "D");
    lookup(12'h000, "zero id");
    lookup(12'hFFF, "top id");
  endtask

  // Watchdog
  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    chk(1'b0, "R12 watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] pool [8];
    void'($urandom(32'd2024));
    rst_n      = 1'b0;
    scan_start = 1'b0;
    lk_req     = 1'b0;
    lk_ppid    = 12'h0;
    for (int c = 0; c < NCH_HI; c++) begin map_mem[c] = 0; own_mem[c] = 0; end
    cur_ver = 0;
    for (int s = 0; s < 4096; s++) exp_valid[s] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state
    chk(scan_busy == 0 && scan_done == 0 && rd_req == 0 && lk_rsp == 0,
        "R1 reset state idle", {scan_busy, scan_done, rd_req, lk_rsp}, 0);
    lookup(12'h0C5, "R9 reset lookup");

    // Directed: duplicates, priority, hand-over, junk bits
    map_mem[2]  = {12'h000, 12'h0C5, 8'h00}; own_mem[2]  = 32'h3;
    map_mem[5]  = {12'h000, 12'h0C5, 8'h11}; own_mem[5]  = 32'h1;
    map_mem[7]  = {12'h000, 12'h0C5, 8'h22}; own_mem[7]  = 32'h4;
    map_mem[9]  = {12'h000, 12'h0C5, 8'h00}; own_mem[9]  = 32'h6;
    map_mem[3]  = {12'h000, 12'h2D3, 8'h00}; own_mem[3]  = 32'h2;
    map_mem[6]  = {12'h000, 12'h2D3, 8'h00}; own_mem[6]  = 32'h5;
    map_mem[10] = {12'h000, 12'h123, 8'h00}; own_mem[10] = 32'h0;
    map_mem[11] = {12'h000, 12'h123, 8'h00}; own_mem[11] = 32'h7;
    map_mem[12] = {12'hFFF, 12'h00A, 8'h5A}; own_mem[12] = 32'hFFFF_FFF9;
    map_mem[14] = {12'h000, 12'h0C5, 8'h00}; own_mem[14] = 32'h9;

    run_scan(32'h7000_0000, 1'b1, 1'b0);   // R3 long scan, R10 probe
    check_list();
    run_scan(32'h5000_0000, 1'b0, 1'b1);   // R3 short scan, R11 restart ignored
    check_list();
    run_scan(32'h4FFF_FFFF, 1'b0, 1'b0);   // R2 unsupported
    check_list();
    run_scan(32'hFFFF_FFFF, 1'b1, 1'b1);
    check_list();

    // Random scans over a small identifier pool
    for (int r = 0; r < 10; r++) begin
      for (int k = 0; k < 8; k++) pool[k] = 12'($urandom);
      for (int c = 0; c < NCH_HI; c++) begin
        if ($urandom % 4 == 0) map_mem[c] = 32'h0;
        else map_mem[c] = {12'($urandom), pool[$urandom % 8], 8'($urandom)};
        own_mem[c] = (($urandom % 3) == 0) ? {29'($urandom), LOCAL_EE} : $urandom;
      end
      case (r % 3)
        0:       run_scan(32'h5000_0000 + ($urandom % 32'h2000_0000), r[0], r[1]);
        1:       run_scan(32'h7000_0000 + ($urandom % 32'h8000_0000), r[0], r[1]);
        default: run_scan(32'h7FFF_FFFF, r[0], r[1]);
      endcase
      for (int k = 0; k < 8; k++) lookup(pool[k], "R5/R7/R8 random");
      lookup(12'($urandom), "R9 random probe");
    end

    // Empty map after a populated one: stale entries must be gone
    for (int c = 0; c < NCH_HI; c++) map_mem[c] = 32'h0;
    run_scan(32'h7000_0000, 1'b0, 1'b0);
    for (int k = 0; k < 8; k++) lookup(pool[k], "R1 cleared by start");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule